// File: doc/BRIEF.md
# Sync table update and host lock arbiter

This block decides when the table writer of a communication controller may refresh the per-cycle sync-frame ID and deviation tables held in shared memory, and when host software may lock a table set to read it without seeing it change. Even-numbered and odd-numbered cycles own separate table sets, and each set has its own lock, valid flag, captured cycle number, entry counts and interrupt flag.

The host programs three configuration bits: an ID-table enable, a deviation-table enable and a one-shot option. These select whether nothing, the ID tables, or both table kinds are refreshed. Refreshes happen either in every cycle or only for the next even/odd pair. At the start of the network idle time of a cycle, the block asks the writer to refresh the tables of that cycle's parity, unless the host holds that parity's lock. The writer answers with a done pulse that carries the entry counts for channels A and B. While a refresh is running, a host lock request stays pending and is granted once the refresh has finished.

In every two-bit vector port, bit 0 belongs to the even table set and bit 1 to the odd table set. In the packed fields, the even set occupies the low slice.

Top module: `sta_lock_arb`

## Requirements
- R1: Copying is active only while the ID enable is 1. With the ID enable at 0, no refresh ever starts, and this includes the reserved setting of deviation enable 1 with ID enable 0. While copying is active, `wr_dev_o` carries the deviation enable, so it is 1 for ID plus deviation and 0 for ID alone.
- R2: With the one-shot option at 0, every network-idle-time start of a cycle whose parity is neither locked by the host nor blocked by a busy writer starts a refresh of that parity.
- R3: A refresh accepted at a clock edge gives a one-cycle `wr_start_o` pulse after that edge. At the same edge, `wr_odd_o` takes bit 0 of the last cycle number seen with `cyc_start_i`, and the valid bit of that parity drops to 0.
- R4: A network-idle-time start for a parity whose lock the host holds starts no refresh, and that parity's valid bit and captured data stay unchanged.
- R5: A host lock trigger is granted at the next edge when no refresh of that parity is running or starting at that edge; the starting refresh wins a tie. A trigger that arrives during a refresh stays pending and is granted at the edge after the one at which `wr_done_i` ends it. Host lock and refresh never coexist for the same parity.
- R6: The `wr_done_i` pulse sets the valid bit and the table-written flag of the parity being refreshed. The `irq_o` bit is 1 only while that flag is 1 and the matching `irq_en_i` bit is 1.
- R7: Writing 1 to a `flag_clr_i` bit clears that flag at the next edge. A flag set by a done pulse at the same edge wins over the clear.
- R8: While a parity's lock is held, `lk_cyc_o` shows the cycle number the refresh of that table started in, and `lk_cnt_a_o` and `lk_cnt_b_o` show the entry counts reported with its done pulse. While the lock is not held, these fields read 0.
- R9: A 1 on an `unlock_i` bit releases that parity's lock and drops any pending request at the next edge.
- R10: With the one-shot option at 1, only an even refresh may start until one has completed; after that, only an odd refresh may start. When the odd refresh completes, hardware clears both enables, and no further refresh starts.
- R11: A network-idle-time start that arrives while a refresh is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | Cycle-start strobe |
| cyc_num_i | input | CYC_W | Number of the starting cycle |
| nit_start_i | input | 1 | Network-idle-time start strobe |
| cfg_wr_i | input | 1 | Host write of the three mode bits |
| cfg_oneshot_i | input | 1 | One-shot option to write |
| cfg_dev_en_i | input | 1 | Deviation-table enable to write |
| cfg_id_en_i | input | 1 | ID-table enable to write |
| lock_trig_i | input | 2 | Host lock trigger per parity |
| unlock_i | input | 2 | Host lock release per parity |
| flag_clr_i | input | 2 | Write-1-to-clear of the table-written flags |
| irq_en_i | input | 2 | Interrupt enables per parity |
| wr_done_i | input | 1 | Writer finished the current refresh |
| wr_cnt_a_i | input | CNT_W | Entries written for channel A |
| wr_cnt_b_i | input | CNT_W | Entries written for channel B |
| wr_start_o | output | 1 | Refresh request pulse to the writer |
| wr_odd_o | output | 1 | Parity of the requested refresh, 1 for odd |
| wr_dev_o | output | 1 | Refresh includes deviation tables |
| id_en_o | output | 1 | Current ID-table enable |
| dev_en_o | output | 1 | Current deviation-table enable |
| oneshot_o | output | 1 | Current one-shot option |
| lock_o | output | 2 | Host lock status per parity |
| valid_o | output | 2 | Table valid per parity |
| flag_o | output | 2 | Table-written flags |
| irq_o | output | 2 | Interrupt requests |
| lk_cyc_o | output | 2*CYC_W | Cycle number of each locked table |
| lk_cnt_a_o | output | 2*CNT_W | Channel A entry count of each locked table |
| lk_cnt_b_o | output | 2*CNT_W | Channel B entry count of each locked table |

## Verification
The properties assume that the writer raises `wr_done_i` only while a refresh it was asked for is running, and that `cyc_start_i` and `nit_start_i` never pulse in the same cycle. The directed tasks keep to both: each done pulse follows a start pulse, and cycle starts and idle-time starts are driven in separate cycles. With the exclusion between lock and refresh taken as given, the properties check that no request is issued for a locked or already-valid table, that flags rise only over valid tables, and that no request follows the reserved or exhausted one-shot setting.

// File: rtl/sta_pkg.sv
package sta_pkg;
   typedef enum logic [1:0] {
      CP_NONE   = 2'd0,
      CP_ID     = 2'd1,
      CP_ID_DEV = 2'd2,
      CP_RSVD   = 2'd3
   } copy_kind_e;

   localparam int unsigned PAR_N = 2;
endpackage

// File: rtl/sta_mode_dec.sv
module sta_mode_dec
   import sta_pkg::*;
(
   input  logic       id_en_i,
   input  logic       dev_en_i,
   output copy_kind_e kind_o,
   output logic       active_o,
   output logic       with_dev_o
);
   always_comb begin
      unique case ({dev_en_i, id_en_i})
         2'b01:   kind_o = CP_ID;
         2'b11:   kind_o = CP_ID_DEV;
         2'b10:   kind_o = CP_RSVD;
         default: kind_o = CP_NONE;
      endcase
   end

   assign active_o   = (kind_o == CP_ID) || (kind_o == CP_ID_DEV);
   assign with_dev_o = (kind_o == CP_ID_DEV);
endmodule

// File: rtl/sta_update_seq.sv
module sta_update_seq #(
   parameter int unsigned CYC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start_i,
   input  logic [CYC_W-1:0] cyc_num_i,
   input  logic             nit_start_i,
   input  logic             cfg_wr_i,
   input  logic             cfg_oneshot_i,
   input  logic             cfg_dev_en_i,
   input  logic             cfg_id_en_i,
   input  logic [1:0]       host_lock_i,
   input  logic             wr_done_i,
   output logic [1:0]       start_o,
   output logic [1:0]       done_o,
   output logic [CYC_W-1:0] cyc_now_o,
   output logic             wr_start_o,
   output logic             wr_odd_o,
   output logic             wr_dev_o,
   output logic             id_en_o,
   output logic             dev_en_o,
   output logic             oneshot_o,
   output logic             busy_o,
   output logic             par_o
);
   import sta_pkg::*;

   logic [CYC_W-1:0] cyc_q;
   logic             id_q, dev_q, one_q, even_seen_q;
   logic             busy_q, par_q;
   logic             start_q, odd_q, devsel_q;
   logic             active, with_dev;
   copy_kind_e       kind;
   logic             par_now, pair_gate, start_any, done_any;

   sta_mode_dec u_dec (
      .id_en_i   (id_q),
      .dev_en_i  (dev_q),
      .kind_o    (kind),
      .active_o  (active),
      .with_dev_o(with_dev)
   );

   assign par_now   = cyc_q[0];
   assign pair_gate = !one_q || (par_now ? even_seen_q : !even_seen_q);
   assign start_any = nit_start_i && active && !busy_q
                      && !host_lock_i[par_now] && pair_gate;
   assign done_any  = wr_done_i && busy_q;

   assign start_o = start_any ? (par_now ? 2'b10 : 2'b01) : 2'b00;
   assign done_o  = done_any  ? (par_q   ? 2'b10 : 2'b01) : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q       <= '0;
         id_q        <= 1'b0;
         dev_q       <= 1'b0;
         one_q       <= 1'b0;
         even_seen_q <= 1'b0;
         busy_q      <= 1'b0;
         par_q       <= 1'b0;
         start_q     <= 1'b0;
         odd_q       <= 1'b0;
         devsel_q    <= 1'b0;
      end else begin
         if (cyc_start_i) cyc_q <= cyc_num_i;
         start_q <= start_any;
         if (start_any) begin
            odd_q    <= par_now;
            devsel_q <= with_dev;
            par_q    <= par_now;
            busy_q   <= 1'b1;
         end else if (done_any) begin
            busy_q <= 1'b0;
         end
         if (cfg_wr_i) begin
            id_q        <= cfg_id_en_i;
            dev_q       <= cfg_dev_en_i;
            one_q       <= cfg_oneshot_i;
            even_seen_q <= 1'b0;
         end else if (done_any && one_q) begin
            if (par_q) begin
               id_q        <= 1'b0;
               dev_q       <= 1'b0;
               even_seen_q <= 1'b0;
            end else begin
               even_seen_q <= 1'b1;
            end
         end
      end
   end

   assign cyc_now_o  = cyc_q;
   assign wr_start_o = start_q;
   assign wr_odd_o   = odd_q;
   assign wr_dev_o   = devsel_q;
   assign id_en_o    = id_q;
   assign dev_en_o   = dev_q;
   assign oneshot_o  = one_q;
   assign busy_o     = busy_q;
   assign par_o      = par_q;
endmodule

// File: rtl/sta_parity_slice.sv
module sta_parity_slice #(
   parameter int unsigned CYC_W = 6,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             unlock_i,
   input  logic             start_i,
   input  logic             done_i,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic [CNT_W-1:0] cnt_a_i,
   input  logic [CNT_W-1:0] cnt_b_i,
   input  logic             flag_clr_i,
   input  logic             irq_en_i,
   output logic             host_lock_o,
   output logic             valid_o,
   output logic             flag_o,
   output logic             irq_o,
   output logic [CYC_W-1:0] cyc_o,
   output logic [CNT_W-1:0] cnt_a_o,
   output logic [CNT_W-1:0] cnt_b_o
);
   logic             host_q, pend_q, ctl_q, valid_q, flag_q;
   logic [CYC_W-1:0] tcyc_q;
   logic [CNT_W-1:0] ca_q, cb_q;
   logic             grant;

   assign grant = (trig_i || pend_q) && !ctl_q && !start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_q  <= 1'b0;
         pend_q  <= 1'b0;
         ctl_q   <= 1'b0;
         valid_q <= 1'b0;
         flag_q  <= 1'b0;
         tcyc_q  <= '0;
         ca_q    <= '0;
         cb_q    <= '0;
      end else begin
         if (start_i) begin
            ctl_q   <= 1'b1;
            valid_q <= 1'b0;
            tcyc_q  <= cyc_i;
         end else if (done_i) begin
            ctl_q   <= 1'b0;
            valid_q <= 1'b1;
            ca_q    <= cnt_a_i;
            cb_q    <= cnt_b_i;
         end
         if (done_i)          flag_q <= 1'b1;
         else if (flag_clr_i) flag_q <= 1'b0;
         if (unlock_i) begin
            host_q <= 1'b0;
            pend_q <= 1'b0;
         end else if (grant) begin
            host_q <= 1'b1;
            pend_q <= 1'b0;
         end else if (trig_i && !host_q) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign host_lock_o = host_q;
   assign valid_o     = valid_q;
   assign flag_o      = flag_q;
   assign irq_o       = flag_q && irq_en_i;
   assign cyc_o       = host_q ? tcyc_q : '0;
   assign cnt_a_o     = host_q ? ca_q   : '0;
   assign cnt_b_o     = host_q ? cb_q   : '0;
endmodule

// File: rtl/sta_lock_arb.sv
module sta_lock_arb #(
   parameter int unsigned CYC_W = 6,
   parameter int unsigned CNT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_start_i,
   input  logic [CYC_W-1:0]   cyc_num_i,
   input  logic               nit_start_i,
   input  logic               cfg_wr_i,
   input  logic               cfg_oneshot_i,
   input  logic               cfg_dev_en_i,
   input  logic               cfg_id_en_i,
   input  logic [1:0]         lock_trig_i,
   input  logic [1:0]         unlock_i,
   input  logic [1:0]         flag_clr_i,
   input  logic [1:0]         irq_en_i,
   input  logic               wr_done_i,
   input  logic [CNT_W-1:0]   wr_cnt_a_i,
   input  logic [CNT_W-1:0]   wr_cnt_b_i,
   output logic               wr_start_o,
   output logic               wr_odd_o,
   output logic               wr_dev_o,
   output logic               id_en_o,
   output logic               dev_en_o,
   output logic               oneshot_o,
   output logic [1:0]         lock_o,
   output logic [1:0]         valid_o,
   output logic [1:0]         flag_o,
   output logic [1:0]         irq_o,
   output logic [2*CYC_W-1:0] lk_cyc_o,
   output logic [2*CNT_W-1:0] lk_cnt_a_o,
   output logic [2*CNT_W-1:0] lk_cnt_b_o
);
   import sta_pkg::*;

   if (CYC_W < 1) begin : g_bad_cyc
      $error("sta_lock_arb: CYC_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sta_lock_arb: CNT_W must be at least 1");
   end

   logic [1:0]       upd_start, upd_done, host_lock;
   logic [CYC_W-1:0] cyc_now;
   logic             upd_busy, upd_par;

   sta_update_seq #(.CYC_W(CYC_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cyc_start_i  (cyc_start_i),
      .cyc_num_i    (cyc_num_i),
      .nit_start_i  (nit_start_i),
      .cfg_wr_i     (cfg_wr_i),
      .cfg_oneshot_i(cfg_oneshot_i),
      .cfg_dev_en_i (cfg_dev_en_i),
      .cfg_id_en_i  (cfg_id_en_i),
      .host_lock_i  (host_lock),
      .wr_done_i    (wr_done_i),
      .start_o      (upd_start),
      .done_o       (upd_done),
      .cyc_now_o    (cyc_now),
      .wr_start_o   (wr_start_o),
      .wr_odd_o     (wr_odd_o),
      .wr_dev_o     (wr_dev_o),
      .id_en_o      (id_en_o),
      .dev_en_o     (dev_en_o),
      .oneshot_o    (oneshot_o),
      .busy_o       (upd_busy),
      .par_o        (upd_par)
   );

   for (genvar p = 0; p < PAR_N; p++) begin : g_par
      sta_parity_slice #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .trig_i     (lock_trig_i[p]),
         .unlock_i   (unlock_i[p]),
         .start_i    (upd_start[p]),
         .done_i     (upd_done[p]),
         .cyc_i      (cyc_now),
         .cnt_a_i    (wr_cnt_a_i),
         .cnt_b_i    (wr_cnt_b_i),
         .flag_clr_i (flag_clr_i[p]),
         .irq_en_i   (irq_en_i[p]),
         .host_lock_o(host_lock[p]),
         .valid_o    (valid_o[p]),
         .flag_o     (flag_o[p]),
         .irq_o      (irq_o[p]),
         .cyc_o      (lk_cyc_o[p*CYC_W +: CYC_W]),
         .cnt_a_o    (lk_cnt_a_o[p*CNT_W +: CNT_W]),
         .cnt_b_o    (lk_cnt_b_o[p*CNT_W +: CNT_W])
      );
   end

   assign lock_o = host_lock;
endmodule

// File: rtl/sta_lock_arb_chk.sv
module sta_lock_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_busy,
   input logic       upd_par,
   input logic       wr_start_o,
   input logic       wr_odd_o,
   input logic       id_en_o,
   input logic       dev_en_o,
   input logic       oneshot_o,
   input logic [1:0] lock_o,
   input logic [1:0] valid_o,
   input logic [1:0] flag_o
);
   // R5: host lock and a running refresh never share a parity
   p_lock_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_busy |-> !lock_o[upd_par]);

   // R4: a request is never issued for a host-locked table
   p_no_req_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> !lock_o[wr_odd_o]);

   // R3: the table being requested is marked not valid
   p_req_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> !valid_o[wr_odd_o]);

   // R6: a table-written flag rises only over a valid table
   p_flag_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[0]) |-> valid_o[0]);
   p_flag_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[1]) |-> valid_o[1]);

   // R1: reserved setting never requests a refresh
   p_rsvd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_en_o && !id_en_o) |=> !wr_start_o);

   // R10: an exhausted one-shot setting requests nothing
   p_oneshot_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (oneshot_o && !id_en_o) |=> !wr_start_o);
endmodule

bind sta_lock_arb sta_lock_arb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_busy  (upd_busy),
   .upd_par   (upd_par),
   .wr_start_o(wr_start_o),
   .wr_odd_o  (wr_odd_o),
   .id_en_o   (id_en_o),
   .dev_en_o  (dev_en_o),
   .oneshot_o (oneshot_o),
   .lock_o    (lock_o),
   .valid_o   (valid_o),
   .flag_o    (flag_o)
);

// File: tb/tb_sta_lock_arb.sv
module tb_sta_lock_arb;
   localparam int unsigned CYC_W = 6;
   localparam int unsigned CNT_W = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cyc_start_i = 1'b0;
   logic [CYC_W-1:0]   cyc_num_i = '0;
   logic               nit_start_i = 1'b0;
   logic               cfg_wr_i = 1'b0;
   logic               cfg_oneshot_i = 1'b0;
   logic               cfg_dev_en_i = 1'b0;
   logic               cfg_id_en_i = 1'b0;
   logic [1:0]         lock_trig_i = '0;
   logic [1:0]         unlock_i = '0;
   logic [1:0]         flag_clr_i = '0;
   logic [1:0]         irq_en_i = '0;
   logic               wr_done_i = 1'b0;
   logic [CNT_W-1:0]   wr_cnt_a_i = '0;
   logic [CNT_W-1:0]   wr_cnt_b_i = '0;
   logic               wr_start_o, wr_odd_o, wr_dev_o;
   logic               id_en_o, dev_en_o, oneshot_o;
   logic [1:0]         lock_o, valid_o, flag_o, irq_o;
   logic [2*CYC_W-1:0] lk_cyc_o;
   logic [2*CNT_W-1:0] lk_cnt_a_o, lk_cnt_b_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sta_lock_arb #(.CYC_W(CYC_W), .CNT_W(CNT_W)) dut (.*);

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic one, input logic dev, input logic id);
      cfg_wr_i = 1'b1; cfg_oneshot_i = one; cfg_dev_en_i = dev; cfg_id_en_i = id;
      tick();
      cfg_wr_i = 1'b0;
   endtask

   task automatic new_cycle(input int num);
      cyc_start_i = 1'b1; cyc_num_i = CYC_W'(num);
      tick();
      cyc_start_i = 1'b0;
   endtask

   // raise the idle-time strobe; on return wr_start_o reflects the decision
   task automatic fire_nit();
      nit_start_i = 1'b1;
      tick();
      nit_start_i = 1'b0;
   endtask

   task automatic finish(input int a, input int b);
      tick();
      wr_done_i = 1'b1; wr_cnt_a_i = CNT_W'(a); wr_cnt_b_i = CNT_W'(b);
      tick();
      wr_done_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R3 reset wr_start", wr_start_o, 0);
      chk("R8 reset lock", lock_o, 0);
      chk("R6 reset valid", valid_o, 0);
      chk("R6 reset flag", flag_o, 0);
      chk("R8 reset lk_cyc", lk_cyc_o, 0);
   endtask

   task automatic t_nocopy();
      set_cfg(0, 0, 0);
      new_cycle(4);
      fire_nit();
      chk("R1 disabled no start", wr_start_o, 0);
      set_cfg(0, 1, 0);
      fire_nit();
      chk("R1 reserved no start", wr_start_o, 0);
      tick();
      chk("R1 reserved valid untouched", valid_o, 0);
   endtask

   task automatic t_cont();
      irq_en_i = 2'b01;
      set_cfg(0, 1, 1);
      new_cycle(6);
      fire_nit();
      chk("R3 even start", wr_start_o, 1);
      chk("R3 even parity", wr_odd_o, 0);
      chk("R1 dev mode", wr_dev_o, 1);
      finish(3, 5);
      chk("R6 even valid", valid_o[0], 1);
      chk("R6 even flag", flag_o[0], 1);
      chk("R6 even irq", irq_o[0], 1);
      new_cycle(7);
      fire_nit();
      chk("R2 odd start", wr_start_o, 1);
      chk("R3 odd parity", wr_odd_o, 1);
      chk("R3 odd valid cleared", valid_o[1], 0);
      finish(2, 1);
      chk("R6 odd flag", flag_o[1], 1);
      chk("R6 odd irq masked", irq_o[1], 0);
      set_cfg(0, 0, 1);
      new_cycle(9);
      fire_nit();
      chk("R1 id-only start", wr_start_o, 1);
      chk("R1 id-only no dev", wr_dev_o, 0);
      finish(2, 2);
   endtask

   task automatic t_flag_clr();
      flag_clr_i = 2'b01;
      tick();
      flag_clr_i = 2'b00;
      chk("R7 even flag cleared", flag_o, 2'b10);
      chk("R7 irq follows", irq_o[0], 0);
      new_cycle(11);
      fire_nit();
      flag_clr_i = 2'b10;
      wr_done_i = 1'b1; wr_cnt_a_i = 4'd1; wr_cnt_b_i = 4'd1;
      tick();
      wr_done_i = 1'b0; flag_clr_i = 2'b00;
      chk("R7 set wins over clear", flag_o[1], 1);
   endtask

   task automatic t_lock();
      lock_trig_i = 2'b01;
      tick();
      lock_trig_i = 2'b00;
      chk("R5 idle grant", lock_o, 2'b01);
      chk("R8 locked cycle", lk_cyc_o[CYC_W-1:0], 6);
      chk("R8 locked count A", lk_cnt_a_o[CNT_W-1:0], 3);
      chk("R8 locked count B", lk_cnt_b_o[CNT_W-1:0], 5);
      chk("R8 odd unlocked reads zero", lk_cyc_o[2*CYC_W-1:CYC_W], 0);
      new_cycle(8);
      fire_nit();
      chk("R4 locked no start", wr_start_o, 0);
      tick();
      chk("R4 valid kept", valid_o[0], 1);
      chk("R4 cycle kept", lk_cyc_o[CYC_W-1:0], 6);
      unlock_i = 2'b01;
      tick();
      unlock_i = 2'b00;
      chk("R9 unlocked", lock_o[0], 0);
      chk("R8 released reads zero", lk_cnt_a_o[CNT_W-1:0], 0);
   endtask

   task automatic t_pending();
      new_cycle(10);
      fire_nit();
      chk("R2 even restart", wr_start_o, 1);
      lock_trig_i = 2'b01;
      tick();
      lock_trig_i = 2'b00;
      chk("R5 held pending", lock_o[0], 0);
      wr_done_i = 1'b1; wr_cnt_a_i = 4'd7; wr_cnt_b_i = 4'd4;
      tick();
      wr_done_i = 1'b0;
      chk("R5 not yet at done", lock_o[0], 0);
      tick();
      chk("R5 granted after done", lock_o[0], 1);
      chk("R8 new count A", lk_cnt_a_o[CNT_W-1:0], 7);
      unlock_i = 2'b01;
      tick();
      unlock_i = 2'b00;
      new_cycle(12);
      nit_start_i = 1'b1; lock_trig_i = 2'b01;
      tick();
      nit_start_i = 1'b0; lock_trig_i = 2'b00;
      chk("R5 start wins tie", wr_start_o, 1);
      chk("R5 tie lock held off", lock_o[0], 0);
      finish(1, 1);
      tick();
      chk("R5 tie later granted", lock_o[0], 1);
      unlock_i = 2'b01;
      tick();
      unlock_i = 2'b00;
   endtask

   task automatic t_busy();
      new_cycle(14);
      fire_nit();
      chk("R11 first start", wr_start_o, 1);
      new_cycle(15);
      fire_nit();
      chk("R11 busy ignores", wr_start_o, 0);
      chk("R11 odd valid kept", valid_o[1], 1);
      finish(1, 1);
   endtask

   task automatic t_oneshot();
      set_cfg(1, 0, 1);
      new_cycle(17);
      fire_nit();
      chk("R10 odd waits for even", wr_start_o, 0);
      new_cycle(18);
      fire_nit();
      chk("R10 even start", wr_start_o, 1);
      finish(2, 3);
      new_cycle(20);
      fire_nit();
      chk("R10 second even refused", wr_start_o, 0);
      new_cycle(21);
      fire_nit();
      chk("R10 odd start", wr_start_o, 1);
      finish(4, 4);
      chk("R10 id cleared", id_en_o, 0);
      chk("R10 dev cleared", dev_en_o, 0);
      new_cycle(22);
      fire_nit();
      chk("R10 stopped", wr_start_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_nocopy();
      t_cont();
      t_flag_clr();
      t_lock();
      t_pending();
      t_busy();
      t_oneshot();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule